// File: doc/BRIEF.md
# Serial Configuration Register Slave for a Clock Generator

This block is the two-wire serial slave that holds the configuration bytes of a system clock generator. A host writes the bytes with a fixed block protocol and can read them back the same way. The register contents drive the output-gating logic of the generator in parallel: one enable per SDRAM clock, one per PCI clock, enables for the two 48 MHz outputs, and the spread-spectrum control.

The serial lines are sampled by the system clock. Each line passes through a two-flop synchronizer and a run-length glitch filter. Start and stop conditions and the clock edges are then detected on the filtered signals. The data line is open-drain: the block only reports when it pulls SDA low, and the board wires that output to the pad together with the host. A write is the write address, a command byte and a count byte, which are acknowledged and thrown away, and then data bytes that fill the register bytes from byte 0 upward. A read is the read address, then a count byte of 6, then bytes 0 to 5. Three bits of byte 3 come back inverted on a read.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset the register image is byte0 = 0x07, byte1 = 0xFF, byte2 = 0xFF, and bytes 3, 4 and 5 = 0x00. SDA is not pulled low.
- R2: The address byte 0xD2 (write) and the address byte 0xD3 (read) are acknowledged. Any other address is not acknowledged. After it, no later byte is acknowledged and no register changes until the next start condition.
- R3: In a write, the two bytes after the address (command, then count) are acknowledged and their values are discarded. The data bytes that follow are acknowledged and stored into byte 0, byte 1 and so on in order. Bits are sent MSB first.
- R4: A stop after any complete data byte ends the write. The bytes already written keep their new values and the remaining bytes keep their old values.
- R5: A data byte beyond byte 5 in one write is not acknowledged and is not stored.
- R6: In a read, the slave sends the value 6 first and then bytes 0 through 5 in order, MSB first, as long as the host acknowledges each byte.
- R7: Byte 3 bits 6..4 are stored as written (visible on cfg_bytes_o) but read back inverted over the bus. Every other bit reads back as stored.
- R8: A repeated start restarts the sequence, so the next write data byte goes to byte 0 again.
- R9: The decoded outputs follow the stored bytes: spread_on_o = NOT byte0 bit 3, dot48_en_o = byte0 bit 2, usb48_en_o = byte0 bit 1, sdram_en_o[i] = byte1 bit i, and pci_en_o[i] = byte2 bit i.
- R10: When the host does not acknowledge a read byte, the slave stops driving SDA until the next start, so any further clocked byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_drive_o | output | 1 | High while the slave pulls SDA low |
| cfg_bytes_o | output | 48 | Register image, byte n at bits 8n+7..8n |
| spread_on_o | output | 1 | Spread spectrum active |
| dot48_en_o | output | 1 | Enable for the 2.5 V 48 MHz output |
| usb48_en_o | output | 1 | Enable for the 3.3 V 48 MHz output |
| sdram_en_o | output | 8 | Per-output enables for the SDRAM clocks |
| pci_en_o | output | 8 | Per-output enables for the PCI clocks |

## Verification
A wrong byte position or a broken ack decision shows up on the bus within the same byte. The acknowledge slot reads high where it should be low, or the reverse, nine serial clocks after the byte starts. A wrong write index or a discarded byte that gets stored anyway shows up on cfg_bytes_o and the decoded enables a few system clocks after the acknowledge slot, and a stop then freezes that value for the comparison. Inversion errors and read-order errors only show in the bytes returned by a block read, so every write scenario is followed by a full read-back, including the case where the host does not acknowledge a read byte.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_WDATA,
    ST_RDATA,
    ST_IGNORE
  } proto_st_t;

  // Reset value of register byte n.
  function automatic logic [7:0] reset_byte(input int n);
    case (n)
      0:       return 8'h07;
      1:       return 8'hFF;
      2:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  // Bits that are returned inverted when byte n is read over the bus.
  function automatic logic [7:0] read_invert_mask(input int n);
    return (n == 3) ? 8'h70 : 8'h00;
  endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      run_q  <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      if (synced == dout) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        dout  <= synced;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic rise_p,
  output logic fall_p,
  output logic start_p,
  output logic stop_p
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign rise_p  =  scl & ~scl_q;
  assign fall_p  = ~scl &  scl_q;
  assign start_p =  scl &  scl_q &  sda_q & ~sda;
  assign stop_p  =  scl &  scl_q & ~sda_q &  sda;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_i2c_pkg::*;
#(
  parameter int NBYTES = 6,
  parameter int IW     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_idx,
  input  logic [7:0]          wr_data,
  input  logic [IW-1:0]       rd_idx,
  output logic [7:0]          rd_data,
  output logic [NBYTES*8-1:0] bytes_o
);
  logic [NBYTES*8-1:0] mem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBYTES; i++) mem_q[i*8 +: 8] <= reset_byte(i);
    end else if (wr_en) begin
      for (int i = 0; i < NBYTES; i++)
        if (wr_idx == IW'(i)) mem_q[i*8 +: 8] <= wr_data;
    end
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NBYTES; i++)
      if (rd_idx == IW'(i)) rd_data = mem_q[i*8 +: 8] ^ read_invert_mask(i);
  end

  assign bytes_o = mem_q;
endmodule

// File: rtl/i2c_cfg_fsm.sv
module i2c_cfg_fsm
  import cfg_i2c_pkg::*;
#(
  parameter int         NBYTES  = 6,
  parameter int         IW      = 3,
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sda,
  input  logic          rise_p,
  input  logic          fall_p,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic [7:0]    rd_data,
  output logic [IW-1:0] rd_idx,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data,
  output logic          sda_drive,
  output logic          ignoring
);
  proto_st_t     st_q;
  logic [3:0]    bit_q;
  logic [7:0]    shift_q;
  logic [7:0]    tx_q;
  logic [IW-1:0] pos_q;
  logic [7:0]    tx_next;

  assign rd_idx   = pos_q - 1'b1;
  assign ignoring = (st_q == ST_IGNORE);

  always_comb begin
    if (pos_q == '0)                   tx_next = 8'(NBYTES);
    else if (pos_q <= IW'(NBYTES))     tx_next = rd_data;
    else                               tx_next = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      shift_q   <= '0;
      tx_q      <= '0;
      pos_q     <= '0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      sda_drive <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_p) begin
        st_q      <= ST_ADDR;
        bit_q     <= '0;
        pos_q     <= '0;
        sda_drive <= 1'b0;
      end else if (stop_p) begin
        st_q      <= ST_IDLE;
        bit_q     <= '0;
        sda_drive <= 1'b0;
      end else if (st_q != ST_IDLE && st_q != ST_IGNORE) begin
        if (rise_p) begin
          if (bit_q < 4'd8) shift_q <= {shift_q[6:0], sda};
          if (bit_q == 4'd8 && st_q == ST_RDATA && sda) st_q <= ST_IGNORE;
          if (bit_q < 4'd9) bit_q <= bit_q + 1'b1;
        end else if (fall_p) begin
          if (bit_q == 4'd8) begin
            case (st_q)
              ST_ADDR: begin
                if (shift_q == WR_ADDR) begin
                  sda_drive <= 1'b1;
                  st_q      <= ST_CMD;
                end else if (shift_q == RD_ADDR) begin
                  sda_drive <= 1'b1;
                  st_q      <= ST_RDATA;
                end else begin
                  st_q <= ST_IGNORE;
                end
              end
              ST_CMD: begin
                sda_drive <= 1'b1;
                st_q      <= ST_CNT;
              end
              ST_CNT: begin
                sda_drive <= 1'b1;
                st_q      <= ST_WDATA;
              end
              ST_WDATA: begin
                if (pos_q < IW'(NBYTES)) begin
                  sda_drive <= 1'b1;
                  wr_en     <= 1'b1;
                  wr_idx    <= pos_q;
                  wr_data   <= shift_q;
                  pos_q     <= pos_q + 1'b1;
                end else begin
                  st_q <= ST_IGNORE;
                end
              end
              default: sda_drive <= 1'b0;
            endcase
          end else if (bit_q == 4'd9) begin
            bit_q <= '0;
            if (st_q == ST_RDATA) begin
              tx_q      <= tx_next;
              sda_drive <= ~tx_next[7];
              if (pos_q <= IW'(NBYTES)) pos_q <= pos_q + 1'b1;
            end else begin
              sda_drive <= 1'b0;
            end
          end else if (bit_q != 4'd0 && st_q == ST_RDATA) begin
            tx_q      <= {tx_q[6:0], 1'b1};
            sda_drive <= ~tx_q[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int         NBYTES      = 6,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter logic [7:0] WR_ADDR     = 8'hD2,
  parameter logic [7:0] RD_ADDR     = 8'hD3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_drive_o,
  output logic [NBYTES*8-1:0] cfg_bytes_o,
  output logic                spread_on_o,
  output logic                dot48_en_o,
  output logic                usb48_en_o,
  output logic [7:0]          sdram_en_o,
  output logic [7:0]          pci_en_o
);
  localparam int IW = $clog2(NBYTES + 2);

  logic [1:0] raw_lines, filt_lines;
  logic rise_w, fall_w, start_w, stop_w;
  logic wr_en_w, ign_w;
  logic [IW-1:0] wr_idx_w, rd_idx_w;
  logic [7:0] wr_data_w, rd_data_w;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) filt_i (
      .clk(clk), .rst(rst), .din(raw_lines[g]), .dout(filt_lines[g])
    );
  end

  i2c_bus_events ev_i (
    .clk(clk), .rst(rst), .scl(filt_lines[0]), .sda(filt_lines[1]),
    .rise_p(rise_w), .fall_p(fall_w), .start_p(start_w), .stop_p(stop_w)
  );

  i2c_cfg_fsm #(.NBYTES(NBYTES), .IW(IW), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) fsm_i (
    .clk(clk), .rst(rst), .sda(filt_lines[1]),
    .rise_p(rise_w), .fall_p(fall_w), .start_p(start_w), .stop_p(stop_w),
    .rd_data(rd_data_w), .rd_idx(rd_idx_w),
    .wr_en(wr_en_w), .wr_idx(wr_idx_w), .wr_data(wr_data_w),
    .sda_drive(sda_drive_o), .ignoring(ign_w)
  );

  cfg_regfile #(.NBYTES(NBYTES), .IW(IW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en_w), .wr_idx(wr_idx_w), .wr_data(wr_data_w),
    .rd_idx(rd_idx_w), .rd_data(rd_data_w), .bytes_o(cfg_bytes_o)
  );

  assign spread_on_o = ~cfg_bytes_o[3];
  assign dot48_en_o  =  cfg_bytes_o[2];
  assign usb48_en_o  =  cfg_bytes_o[1];
  assign sdram_en_o  =  cfg_bytes_o[15:8];
  assign pci_en_o    =  cfg_bytes_o[23:16];
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk
  import cfg_i2c_pkg::*;
#(
  parameter int NBYTES = 6,
  parameter int IW     = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                scl_i,
  input logic                sda_drive_o,
  input logic [NBYTES*8-1:0] cfg_bytes_o,
  input logic                ignoring,
  input logic                wr_en,
  input logic [IW-1:0]       wr_idx
);
  logic [NBYTES*8-1:0] def_img;
  always_comb
    for (int i = 0; i < NBYTES; i++) def_img[i*8 +: 8] = reset_byte(i);

  // R1: register image holds the defaults on leaving reset
  a_r1_reset_image: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cfg_bytes_o == def_img));

  // R2: an ignored transaction never pulls SDA low
  a_r2_ignore_silent: assert property (@(posedge clk) disable iff (rst)
    ignoring |-> !sda_drive_o);

  // R3: register bytes only change while the serial clock is low
  a_r3_cfg_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_bytes_o) |-> !scl_i);

  // R5: no write ever targets a byte past the last one
  a_r5_index_bound: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < IW'(NBYTES)));

  // R6: the slave changes SDA only while the serial clock is low
  a_r6_drive_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_drive_o) |-> !scl_i);
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NBYTES(NBYTES), .IW(IW)) chk_i (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_drive_o(sda_drive_o),
  .cfg_bytes_o(cfg_bytes_o), .ignoring(ign_w), .wr_en(wr_en_w), .wr_idx(wr_idx_w)
);

// File: tb/cfg_i2c_slave_tb_top.sv
module cfg_i2c_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 20;

  logic clk = 0, rst = 1;
  logic scl_m = 1, m_low = 0;
  logic sda_bus;
  logic sda_drive;
  logic [47:0] cfg;
  logic spread_on, dot48, usb48;
  logic [7:0] sdram_en, pci_en;

  int checks = 0, fails = 0;
  logic [7:0] exp_b [6];

  assign sda_bus = ~(m_low | sda_drive);

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_i2c_slave dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_drive_o(sda_drive),
    .cfg_bytes_o(cfg), .spread_on_o(spread_on), .dot48_en_o(dot48), .usb48_en_o(usb48),
    .sdram_en_o(sdram_en), .pci_en_o(pci_en)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #2;
  endtask

  task automatic bit_out(input logic b);
    m_low = ~b; wq(); scl_m = 1; wq(); wq(); scl_m = 0; wq();
  endtask

  task automatic bit_in(output logic b);
    m_low = 0; wq(); scl_m = 1; wq(); b = sda_bus; wq(); scl_m = 0; wq();
  endtask

  task automatic do_start();
    m_low = 0; wq(); scl_m = 1; wq(); m_low = 1; wq(); scl_m = 0; wq();
  endtask

  task automatic do_stop();
    m_low = 1; wq(); scl_m = 1; wq(); m_low = 0; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic host_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(~host_ack);
  endtask

  function automatic logic [47:0] exp_img();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = exp_b[i];
    return v;
  endfunction

  task automatic write_hdr(input string tag);
    logic a;
    do_start();
    send_byte(8'hD2, a); chk({tag, " addr D2 ack"}, a, 1);
    send_byte(8'h5A, a); chk({tag, " cmd ack"}, a, 1);
    send_byte(8'h33, a); chk({tag, " count ack"}, a, 1);
  endtask

  task automatic t_reset();
    chk("R1 reset image", cfg, 48'h000000FFFF07);
    chk("R1 no drive", sda_drive, 0);
    chk("R9 reset decode", {spread_on, dot48, usb48, sdram_en, pci_en}, {3'b111, 8'hFF, 8'hFF});
  endtask

  task automatic t_full_write();
    logic a;
    logic [7:0] d [6] = '{8'h0A, 8'h3C, 8'hC3, 8'h50, 8'h11, 8'h99};
    write_hdr("R2 R3");
    for (int i = 0; i < 6; i++) begin
      send_byte(d[i], a); chk("R3 data ack", a, 1);
      exp_b[i] = d[i];
    end
    do_stop();
    chk("R3 stored image", cfg, exp_img());
    chk("R7 stored byte3 uninverted", cfg[31:24], 8'h50);
    chk("R9 decode", {spread_on, dot48, usb48, sdram_en, pci_en}, {3'b001, 8'h3C, 8'hC3});
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    do_start();
    send_byte(8'hD3, a); chk("R2 addr D3 ack", a, 1);
    recv_byte(1, d); chk("R6 count", d, 8'd6);
    for (int i = 0; i < 6; i++) begin
      recv_byte(i != 5, d);
      chk((i == 3) ? "R7 byte3 inverted" : "R6 read byte", d,
          (i == 3) ? (exp_b[3] ^ 8'h70) : exp_b[i]);
    end
    do_stop();
  endtask

  task automatic t_nack_release();
    logic a;
    logic [7:0] d;
    do_start();
    send_byte(8'hD3, a); chk("R10 addr ack", a, 1);
    recv_byte(1, d); chk("R10 count", d, 8'd6);
    recv_byte(0, d); chk("R10 byte0", d, exp_b[0]);
    recv_byte(0, d); chk("R10 released after nack", d, 8'hFF);
    do_stop();
  endtask

  task automatic t_partial();
    logic a;
    write_hdr("R4");
    send_byte(8'h81, a); chk("R4 ack0", a, 1);
    send_byte(8'h42, a); chk("R4 ack1", a, 1);
    do_stop();
    exp_b[0] = 8'h81; exp_b[1] = 8'h42;
    chk("R4 partial image", cfg, exp_img());
  endtask

  task automatic t_overflow();
    logic a;
    logic [7:0] d [6] = '{8'h06, 8'hF0, 8'h0F, 8'h70, 8'h22, 8'h44};
    write_hdr("R5");
    for (int i = 0; i < 6; i++) begin send_byte(d[i], a); exp_b[i] = d[i]; end
    send_byte(8'hEE, a); chk("R5 extra byte not acked", a, 0);
    do_stop();
    chk("R5 image after overflow", cfg, exp_img());
  endtask

  task automatic t_bad_addr();
    logic a;
    do_start();
    send_byte(8'hA4, a); chk("R2 bad addr nack", a, 0);
    send_byte(8'h12, a); chk("R2 ignored byte nack", a, 0);
    send_byte(8'h34, a); chk("R2 ignored byte2 nack", a, 0);
    do_stop();
    chk("R2 image unchanged", cfg, exp_img());
  endtask

  task automatic t_rstart();
    logic a;
    write_hdr("R8");
    send_byte(8'h77, a);
    write_hdr("R8 again");
    send_byte(8'h66, a); chk("R8 byte0 ack", a, 1);
    send_byte(8'h55, a); chk("R8 byte1 ack", a, 1);
    do_stop();
    exp_b[0] = 8'h66; exp_b[1] = 8'h55;
    chk("R8 restart to byte0", cfg, exp_img());
  endtask

  initial begin
    exp_b = '{8'h07, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00};
    repeat (5) @(posedge clk);
    #2 rst = 0;
    repeat (5) @(posedge clk);
    #2;
    t_reset();
    t_full_write();
    t_read();
    t_nack_release();
    t_partial();
    t_bad_addr();
    t_read();
    t_overflow();
    t_read();
    t_rstart();
    t_read();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule